// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port and an external asynchronous static RAM of 256K words by 16 bits. The RAM is driven through active-low chip select, write enable, output enable and two byte-lane selects, and it shares one bidirectional 16-bit data bus. The clocked side offers one request at a time: an address, a write flag, a two-bit lane mask and write data. The block then runs the strobe sequence and returns a one-cycle completion pulse. For reads, that pulse comes with the captured word.

No clock reaches the RAM. Every strobe width and turnaround gap is a cycle count. Each count is computed at elaboration from a nanosecond timing parameter and the clock period parameter. The rule is the ceiling of nanoseconds over period, and never less than one cycle. When several timing limits bound the same interval, the largest count wins. A request is latched when it is accepted, and nothing on the request inputs affects the running access after that.

Top module: `sram_async_ctl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, chip select, write enable, output enable and both lane selects are high (inactive), and the block leaves the data bus undriven.
- R2: A read holds chip select and output enable low and write enable high for RD_CYC cycles. RD_CYC is the largest of ceil(tRC/period), ceil(tAA/period) and ceil(tOE/period), which is 14 at 4 ns. Lane-select bit 0 (lower lane, data bits 7:0) is low only when mask bit 0 is set. Lane-select bit 1 (upper lane, data bits 15:8) is low only when mask bit 1 is set.
- R3: Read data is sampled on the clock edge that ends the read window. On the following cycle `rsp_done` is high for one cycle and `rsp_rdata` holds the word. Any lane not set in the mask reads as zero.
- R4: A write holds chip select, write enable and the selected lane selects low together for WR_CYC cycles. WR_CYC is the largest of the counts for tWP, tAW, tCW, tDW and tWC, which is 14 at 4 ns. Output enable stays high for the whole write. `rsp_done` pulses on the cycle after the window closes.
- R5: The block drives the data bus only while write enable is low. Only lanes whose select is low are written into the RAM.
- R6: After a read window, all strobes stay high and `req_ready` stays low for FLT_CYC cycles, which is ceil(tHZ/period) = 5 at 4 ns. Write enable therefore never falls sooner than FLT_CYC cycles after output enable rises.
- R7: A request with mask 00 completes with `rsp_done` on the next cycle, produces no strobe activity, and leaves the RAM contents unchanged.
- R8: Address, lane selects and write data are latched at acceptance and stay stable for the whole access, whatever the request inputs do afterwards.
- R9: A request is taken only in a cycle where `req_ready` is high. A `req_valid` seen while the block is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when valid is high |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done after a read |
| sram_addr | output | 18 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_bs_n | output | 2 | RAM lane selects, active low, bit 0 lower |
| sram_dq | inout | 16 | Shared RAM data bus |

## Verification
The hardest condition to reach from the ports is a write that directly follows a read. The write must wait out the float gap, and it may not overlap the RAM's read drive. The bench chains such read-then-write pairs, both directed and in the random mix, and counts how many cycles `req_ready` stays low. It also checks for a floating bus at every negative edge. A second hard case is a request input that changes or re-asserts while an access is in flight. The bench scrambles address and data right after acceptance and holds `req_valid` high with a stray write during a busy read. Later reads of the targeted words show whether any of that leaked into memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_FLOAT = 2'd2,
      ST_WRITE = 2'd3
   } sram_st_e;

   // Cycles needed to cover a nanosecond interval, never fewer than one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC  = 14,
   parameter int unsigned WR_CYC  = 14,
   parameter int unsigned FLT_CYC = 5,
   parameter int unsigned CNT_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_any,
   output logic ready,
   output logic accept,
   output logic cap_en,
   output logic done,
   output logic cs_act,
   output logic we_act,
   output logic oe_act
);

   sram_st_e         state;
   logic [CNT_W-1:0] cnt;
   logic             last;

   assign ready  = (state == ST_IDLE);
   assign accept = ready && req_valid;
   assign last   = (cnt == '0);
   assign cap_en = (state == ST_READ) && last;
   assign cs_act = (state == ST_READ) || (state == ST_WRITE);
   assign we_act = (state == ST_WRITE);
   assign oe_act = (state == ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (!req_any) begin
                     done <= 1'b1;
                  end else if (req_write) begin
                     state <= ST_WRITE;
                     cnt   <= CNT_W'(WR_CYC - 1);
                  end else begin
                     state <= ST_READ;
                     cnt   <= CNT_W'(RD_CYC - 1);
                  end
               end
            end
            ST_READ: begin
               if (last) begin
                  state <= ST_FLOAT;
                  cnt   <= CNT_W'(FLT_CYC - 1);
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_FLOAT: begin
               if (last) state <= ST_IDLE;
               else      cnt   <= cnt - 1'b1;
            end
            ST_WRITE: begin
               if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // The pulse must follow an active window or be a mask-00 completion.
   AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(cs_act) || $past(ready))); // R3

endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cap_en,
   input  logic              cs_act,
   input  logic              we_act,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  bs_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned LANE_W = DATA_W / LANES;

   logic [LANES-1:0]  mask_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mask_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         mask_q  <= req_mask;
         wdata_q <= req_wdata;
      end
   end

   assign dq_out = wdata_q;
   assign dq_oe  = we_act;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cap_q;
      assign bs_n[g] = !(cs_act && mask_q[g]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cap_q <= '0;
         else if (cap_en) cap_q <= mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
      assign rdata[g*LANE_W +: LANE_W] = cap_q;
   end

   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act)) |-> $stable(addr_q)); // R8
   AST_HOLD_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R8
   AST_DRIVE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (bs_n != '1)); // R5

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned LANES         = 2,
   parameter int unsigned T_RC_NS       = 55,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_OE_NS       = 35,
   parameter int unsigned T_WP_NS       = 40,
   parameter int unsigned T_AW_NS       = 50,
   parameter int unsigned T_CW_NS       = 50,
   parameter int unsigned T_DW_NS       = 25,
   parameter int unsigned T_WC_NS       = 55,
   parameter int unsigned T_HZ_NS       = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [LANES-1:0]  sram_bs_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int unsigned RD_CYC = umax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                    umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
   localparam int unsigned WR_CYC = umax(umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                    umax(umax(ns_to_cyc(T_CW_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)),
                                         ns_to_cyc(T_WC_NS, CLK_PERIOD_NS)));
   localparam int unsigned FLT_CYC = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
   localparam int unsigned MAX_CYC = umax(RD_CYC, umax(WR_CYC, FLT_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned RUN_W   = CNT_W + 1;

   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be nonzero");
   end
   if (LANES == 0 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES");
   end

   logic accept, cap_en, cs_act, we_act, oe_act, dq_oe;
   logic [DATA_W-1:0] dq_out;

   sram_ctl_seq #(
      .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .FLT_CYC(FLT_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_any(|req_mask),
      .ready(req_ready), .accept(accept), .cap_en(cap_en), .done(rsp_done),
      .cs_act(cs_act), .we_act(we_act), .oe_act(oe_act)
   );

   sram_ctl_lanes #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
   ) u_lanes (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
      .cap_en(cap_en), .cs_act(cs_act), .we_act(we_act), .dq_in(sram_dq),
      .addr_q(sram_addr), .bs_n(sram_bs_n), .dq_out(dq_out), .dq_oe(dq_oe),
      .rdata(rsp_rdata)
   );

   assign sram_cs_n = !cs_act;
   assign sram_we_n = !we_act;
   assign sram_oe_n = !oe_act;
   assign sram_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};

   // Low-run and float-gap counters for the interval checks.
   logic [RUN_W-1:0] we_run;
   logic [RUN_W-1:0] flt_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run  <= '0;
         flt_run <= RUN_W'(FLT_CYC);
      end else begin
         we_run  <= sram_we_n ? '0 : ((we_run == '1) ? we_run : we_run + 1'b1);
         flt_run <= !sram_oe_n ? '0 :
                    ((flt_run >= RUN_W'(FLT_CYC)) ? flt_run : flt_run + 1'b1);
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && (&sram_bs_n))); // R1
   AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n); // R4
   AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_run == RUN_W'(WR_CYC))); // R4
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> (flt_run >= RUN_W'(FLT_CYC))); // R6
   AST_NO_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && req_valid) |=> $stable(sram_addr) || !sram_cs_n || req_ready); // R9

endmodule

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;

   localparam int PER = 4;
   function automatic int cdiv(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   localparam int RD  = (cdiv(55) > cdiv(35)) ? cdiv(55) : cdiv(35);
   localparam int WR  = (cdiv(55) > cdiv(50)) ? cdiv(55) : cdiv(50);
   localparam int FLT = cdiv(20);

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic        req_valid = 0, req_write = 0;
   logic [17:0] req_addr = 0;
   logic [1:0]  req_mask = 0;
   logic [15:0] req_wdata = 0;
   wire         req_ready, rsp_done;
   wire  [15:0] rsp_rdata;
   wire  [17:0] sram_addr;
   wire         sram_cs_n, sram_we_n, sram_oe_n;
   wire  [1:0]  sram_bs_n;
   wire  [15:0] sram_dq;

   sram_async_ctl #(.CLK_PERIOD_NS(PER)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
      .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_bs_n(sram_bs_n), .sram_dq(sram_dq));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] seed_word(input logic [17:0] a);
      return a[15:0] ^ 16'hA55A ^ {a[17:16], 14'd0};
   endfunction

   // RAM model and expected image.
   logic [15:0] mem [int];
   logic [15:0] expm [int];
   logic        mrd = 0;
   logic [15:0] mdata = 0;
   assign sram_dq = mrd ? mdata : 16'bz;

   function automatic logic [15:0] exp_word(input logic [17:0] a);
      return expm.exists(int'(a)) ? expm[int'(a)] : seed_word(a);
   endfunction

   int bad_float = 0, bad_oe = 0, bad_addr = 0, bad_idle = 0;
   logic [17:0] prev_addr = 0;
   logic        prev_cs = 1;

   always @(negedge clk) begin
      logic [15:0] cur;
      cur = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : seed_word(sram_addr);
      if (rst_n && !sram_cs_n && !sram_we_n) begin
         if (!sram_bs_n[0]) cur[7:0]  = sram_dq[7:0];
         if (!sram_bs_n[1]) cur[15:8] = sram_dq[15:8];
         mem[int'(sram_addr)] = cur;
      end
      mrd   <= !sram_cs_n && !sram_oe_n && sram_we_n;
      mdata <= cur;
      if (rst_n) begin
         if (sram_we_n && !mrd && sram_dq !== 16'bz) bad_float++;
         if (!sram_we_n && !sram_oe_n) bad_oe++;
         if (!sram_cs_n && !prev_cs && sram_addr !== prev_addr) bad_addr++;
         if (req_ready && !(sram_cs_n && sram_we_n && sram_oe_n && &sram_bs_n)) bad_idle++;
      end
      prev_addr = sram_addr;
      prev_cs   = sram_cs_n;
   end

   // One access; poke holds a stray write request during the first busy cycles.
   task automatic access(input logic [17:0] a, input bit w, input logic [1:0] m,
                         input logic [15:0] d, input bit poke);
      int n, cs_lo, we_lo, oe_lo, k;
      logic [15:0] e;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_addr = a; req_write = w; req_mask = m; req_wdata = d;
      @(negedge clk);
      req_valid = poke; req_write = 1; req_mask = 2'b11;
      req_addr = 18'($urandom); req_wdata = 16'($urandom);
      n = 1; cs_lo = 0; we_lo = 0; oe_lo = 0;
      if (m != 0)
         chk(sram_bs_n == ~m, "R2", "lane selects", sram_bs_n, ~m);
      while (!rsp_done && n < 100) begin
         if (!sram_cs_n) cs_lo++;
         if (!sram_we_n) we_lo++;
         if (!sram_oe_n) oe_lo++;
         if (n == 3) req_valid = 0;
         @(negedge clk); n++;
      end
      req_valid = 0;
      if (m == 0) begin
         chk(n == 1 && cs_lo == 0, "R7", "mask00 latency/activity", n * 256 + cs_lo, 1 * 256);
      end else if (w) begin
         chk(n == WR + 1, "R4", "write latency", n, WR + 1);
         chk(we_lo == WR && cs_lo == WR && oe_lo == 0, "R4", "write strobe cycles",
             we_lo * 65536 + cs_lo * 256 + oe_lo, WR * 65536 + WR * 256);
         e = exp_word(a);
         if (m[0]) e[7:0]  = d[7:0];
         if (m[1]) e[15:8] = d[15:8];
         expm[int'(a)] = e;
      end else begin
         chk(n == RD + 1, "R2", "read latency", n, RD + 1);
         chk(oe_lo == RD && cs_lo == RD && we_lo == 0, "R2", "read strobe cycles",
             oe_lo * 65536 + cs_lo * 256 + we_lo, RD * 65536 + RD * 256);
         e = exp_word(a) & {{8{m[1]}}, {8{m[0]}}};
         chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
         @(negedge clk);
         chk(!rsp_done, "R3", "done single cycle", rsp_done, 0);
         k = 1;
         while (!req_ready && k < 100) begin @(negedge clk); k++; end
         chk(k == FLT, "R6", "float gap cycles", k, FLT);
      end
   endtask

   logic [17:0] pool [8];

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(sram_cs_n && sram_we_n && sram_oe_n && sram_bs_n == 2'b11 && sram_dq === 16'bz,
          "R1", "strobes in reset", {sram_cs_n, sram_we_n, sram_oe_n, sram_bs_n}, 5'h1F);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !rsp_done, "R1", "ready after reset", {req_ready, rsp_done}, 2'b10);

      // Directed cases.
      access(18'h00123, 1, 2'b11, 16'hBEEF, 0);
      access(18'h00123, 0, 2'b11, 16'h0, 0);
      access(18'h00123, 1, 2'b01, 16'h1234, 0);          // R5 lower lane only
      access(18'h00123, 0, 2'b11, 16'h0, 0);
      access(18'h00123, 1, 2'b10, 16'h5600, 0);          // R5 upper lane only
      access(18'h00123, 0, 2'b01, 16'h0, 0);             // R3 upper zeroed
      access(18'h00123, 0, 2'b10, 16'h0, 0);             // R3 lower zeroed
      access(18'h00123, 1, 2'b00, 16'hFFFF, 0);          // R7 no write
      access(18'h00123, 0, 2'b11, 16'h0, 0);
      access(18'h3FFFF, 0, 2'b11, 16'h0, 1);             // R9 stray request while busy
      access(18'h3FFFF, 1, 2'b11, 16'hC0DE, 0);          // R6 read then write
      access(18'h00000, 1, 2'b11, 16'h0F0F, 1);          // R8 inputs change mid-write
      access(18'h3FFFF, 0, 2'b11, 16'h0, 0);
      access(18'h00000, 0, 2'b11, 16'h0, 0);

      // Random mix over a small address pool.
      pool[0] = 18'h0; pool[1] = 18'h3FFFF;
      for (int i = 2; i < 8; i++) pool[i] = 18'($urandom);
      for (int i = 0; i < 150; i++) begin
         logic [17:0] a;
         a = pool[$urandom_range(0, 7)];
         access(a, 1'($urandom), 2'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0));
      end
      for (int i = 0; i < 8; i++) access(pool[i], 0, 2'b11, 16'h0, 0);

      chk(bad_float == 0, "R5", "bus driven outside write", bad_float, 0);
      chk(bad_oe == 0, "R4", "output enable during write", bad_oe, 0);
      chk(bad_addr == 0, "R8", "address moved mid-access", bad_addr, 0);
      chk(bad_idle == 0, "R1", "strobe active while ready", bad_idle, 0);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * PER);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule